// File: doc/BRIEF.md
# Bus-Off Recovery Error Counter

This block handles the bus-off phase of a CAN node's fault confinement. A bus-off event makes the node go bus-off. The receive error count is cleared. The transmit error count is loaded with 127. The node is then held in reset mode until it has seen enough idle bus. During recovery the block reuses the transmit error count as a down-counter. Each group of eleven consecutive recessive bit samples removes one from it. When the group after the one that reached zero completes, the node leaves bus-off and a one-cycle completion pulse is issued. Recovery therefore takes 128 groups.

Bits reach the block as a strobe and a sampled level. It does no bit timing and decodes no frames. The normal rules for raising and lowering the error counts are out of scope, so outside a bus-off event and recovery the counts hold their values. An error-warning interrupt request is raised on bus-off when it is enabled. It stays set until it is cleared.

Top module: `busoff_recovery_counter`

## Requirements
- R1: One clock after `bus_off_evt` is high, `rx_err_cnt` is 0.
- R2: One clock after `bus_off_evt` is high, `tx_err_cnt` is 127 and `bus_off` is 1. While `bus_off` is 1 the controller is held in reset mode.
- R3: While `bus_off` is 1, `tx_err_cnt` decreases by one, one clock after each completed group of 11 consecutive recessive samples. A sample exists only in a cycle with `bit_strobe` high, and `bus_level` = 1 means recessive. In every other cycle `tx_err_cnt` holds its value, including when `bus_off` is 0.
- R4: A dominant sample (`bus_level` = 0 with the strobe) restarts the run of recessive samples from zero. After each completed group the run restarts from zero, so groups never overlap.
- R5: The group that completes while `tx_err_cnt` is 0 is the 128th group. One clock after that group, `bus_off` is 0 and `recovery_done` is 1 for exactly one cycle, and `tx_err_cnt` stays 0.
- R6: `warn_irq` becomes 1 one clock after `bus_off_evt` when `warn_irq_en` is 1. When `warn_irq_en` is 0, a bus-off event does not change `warn_irq`.
- R7: `warn_irq` stays 1 until a cycle with `irq_clear` high, after which it is 0. In a cycle that has both a set and `irq_clear`, the set wins.
- R8: A `bus_off_evt` during recovery reloads `tx_err_cnt` with 127 and discards the partial run of recessive samples.
- R9: After reset, `tx_err_cnt`, `rx_err_cnt`, `bus_off`, `warn_irq` and `recovery_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_strobe | input | 1 | High for one cycle per sampled bus bit |
| bus_level | input | 1 | Sampled bus level: 1 recessive, 0 dominant |
| bus_off_evt | input | 1 | Bus-off condition detected |
| warn_irq_en | input | 1 | Error-warning interrupt enable |
| irq_clear | input | 1 | Clears the error-warning interrupt request |
| tx_err_cnt | output | 8 | Transmit error count, the recovery down-counter while bus-off |
| rx_err_cnt | output | 8 | Receive error count |
| bus_off | output | 1 | Node is bus-off and held in reset mode |
| warn_irq | output | 1 | Error-warning interrupt request |
| recovery_done | output | 1 | One-cycle pulse when recovery completes |

## Verification
The hardest case to reach is the end of recovery. It needs 1408 clean recessive samples after the last bus-off event, and a single dominant sample anywhere in a group throws that group's progress away. The stimulus first walks the counter down in long recessive stretches. At chosen counts it inserts runs of ten recessive samples followed by a dominant one, and sends a second bus-off event partway through a run. It then completes a full recovery, and a cycle-by-cycle model in the bench predicts the exact cycle of the completion pulse.

// File: rtl/bor_pkg.sv
package bor_pkg;

  // Next value of the recessive run length after one sample.
  function automatic int unsigned run_next(int unsigned run, logic recessive,
                                           int unsigned group_len);
    if (!recessive) return 0;
    if (run + 1 >= group_len) return 0;
    return run + 1;
  endfunction

  // A sample closes a group when it is recessive and the run is one short.
  function automatic logic closes_group(int unsigned run, logic recessive,
                                        int unsigned group_len);
    return recessive && (run + 1 == group_len);
  endfunction

  // Transmit error count after one completed recovery group.
  function automatic int unsigned tec_after_group(int unsigned tec);
    return (tec == 0) ? 0 : tec - 1;
  endfunction

endpackage

// File: rtl/bor_run_tracker.sv
module bor_run_tracker #(
  parameter int unsigned RUN_LEN = 11,
  localparam int unsigned RUN_W = $clog2(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic             strobe,
  input  logic             level,
  output logic             group_done,
  output logic [RUN_W-1:0] run_len
);

  logic [RUN_W-1:0] run_q;

  assign run_len    = run_q;
  assign group_done = active && !restart && strobe &&
                      bor_pkg::closes_group(int'(run_q), level, RUN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!active || restart)
      run_q <= '0;
    else if (strobe)
      run_q <= RUN_W'(bor_pkg::run_next(int'(run_q), level, RUN_LEN));
  end

  AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe && !level) |=> (run_q == '0)); // R4

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_W'(RUN_LEN)); // R4

  AST_GROUP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |=> (run_q == '0)); // R4

endmodule

// File: rtl/bor_fault_counters.sv
module bor_fault_counters #(
  parameter int unsigned TEC_W  = 8,
  parameter int unsigned PRESET = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_off_evt,
  input  logic             group_done,
  output logic [TEC_W-1:0] tx_err_cnt,
  output logic [TEC_W-1:0] rx_err_cnt,
  output logic             bus_off,
  output logic             recovery_done
);

  logic tec_at_zero;
  assign tec_at_zero = (tx_err_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_err_cnt    <= '0;
      rx_err_cnt    <= '0;
      bus_off       <= 1'b0;
      recovery_done <= 1'b0;
    end else begin
      recovery_done <= 1'b0;
      if (bus_off_evt) begin
        tx_err_cnt <= TEC_W'(PRESET);
        rx_err_cnt <= '0;
        bus_off    <= 1'b1;
      end else if (group_done) begin
        if (tec_at_zero) begin
          bus_off       <= 1'b0;
          recovery_done <= 1'b1;
        end else begin
          tx_err_cnt <= TEC_W'(bor_pkg::tec_after_group(int'(tx_err_cnt)));
        end
      end
    end
  end

  AST_RX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_evt |=> (rx_err_cnt == '0)); // R1

  AST_TX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_evt |=> (tx_err_cnt == TEC_W'(PRESET) && bus_off)); // R2

  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (group_done && !bus_off_evt && !tec_at_zero) |=>
      (tx_err_cnt == TEC_W'($past(tx_err_cnt) - 1'b1))); // R3

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!group_done && !bus_off_evt) |=> $stable(tx_err_cnt)); // R3

  AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |-> (!bus_off && tx_err_cnt == '0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |=> !recovery_done); // R5

endmodule

// File: rtl/bor_warn_irq.sv
module bor_warn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_off_evt,
  input  logic enable,
  input  logic clear,
  output logic irq
);

  logic set_req;
  assign set_req = bus_off_evt && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (set_req)
      irq <= 1'b1;
    else if (clear)
      irq <= 1'b0;
  end

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irq); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear) |=> irq); // R7

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !set_req) |=> !irq); // R7

endmodule

// File: rtl/busoff_recovery_counter.sv
module busoff_recovery_counter #(
  parameter int unsigned TEC_W   = 8,
  parameter int unsigned PRESET  = 127,
  parameter int unsigned RUN_LEN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             bus_level,
  input  logic             bus_off_evt,
  input  logic             warn_irq_en,
  input  logic             irq_clear,
  output logic [TEC_W-1:0] tx_err_cnt,
  output logic [TEC_W-1:0] rx_err_cnt,
  output logic             bus_off,
  output logic             warn_irq,
  output logic             recovery_done
);

  localparam int unsigned RUN_W = $clog2(RUN_LEN);

  logic             group_done;
  logic [RUN_W-1:0] run_len;

  bor_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (bus_off),
    .restart    (bus_off_evt),
    .strobe     (bit_strobe),
    .level      (bus_level),
    .group_done (group_done),
    .run_len    (run_len)
  );

  bor_fault_counters #(.TEC_W(TEC_W), .PRESET(PRESET)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_off_evt   (bus_off_evt),
    .group_done    (group_done),
    .tx_err_cnt    (tx_err_cnt),
    .rx_err_cnt    (rx_err_cnt),
    .bus_off       (bus_off),
    .recovery_done (recovery_done)
  );

  bor_warn_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_off_evt (bus_off_evt),
    .enable      (warn_irq_en),
    .clear       (irq_clear),
    .irq         (warn_irq)
  );

  AST_NO_GROUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_off |-> !group_done); // R3

  AST_EVT_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_evt |=> (run_len == '0)); // R8

endmodule

// File: tb/busoff_recovery_counter_test.sv
module busoff_recovery_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_strobe = 1'b0, bus_level = 1'b1, bus_off_evt = 1'b0;
  logic       warn_irq_en = 1'b0, irq_clear = 1'b0;
  logic [7:0] tx_err_cnt, rx_err_cnt;
  logic       bus_off, warn_irq, recovery_done;

  always #10 clk = ~clk; // 50 MHz

  busoff_recovery_counter uut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bus_level(bus_level),
    .bus_off_evt(bus_off_evt), .warn_irq_en(warn_irq_en), .irq_clear(irq_clear),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .bus_off(bus_off),
    .warn_irq(warn_irq), .recovery_done(recovery_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_tec = 0, m_rec = 0, m_run = 0;
  bit m_off = 0, m_irq = 0, m_done = 0;
  int done_pulses = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3", "tx_err_cnt", int'(tx_err_cnt), m_tec);
    check("R1", "rx_err_cnt", int'(rx_err_cnt), m_rec);
    check("R2", "bus_off", int'(bus_off), int'(m_off));
    check("R7", "warn_irq", int'(warn_irq), int'(m_irq));
    check("R5", "recovery_done", int'(recovery_done), int'(m_done));
  endtask

  // Apply one cycle of inputs, advance the model, compare after the edge.
  task automatic cyc(bit stb, bit lvl, bit evt = 0, bit en = 0, bit clr = 0);
    bit grp;
    bit_strobe = stb; bus_level = lvl; bus_off_evt = evt;
    warn_irq_en = en; irq_clear = clr;
    @(posedge clk);
    m_done = 0;
    grp = 0;
    if (evt) begin
      m_tec = 127; m_rec = 0; m_off = 1; m_run = 0;
    end else if (m_off && stb) begin
      if (!lvl) m_run = 0;
      else begin
        m_run++;
        if (m_run == 11) begin m_run = 0; grp = 1; end
      end
      if (grp) begin
        if (m_tec == 0) begin m_off = 0; m_done = 1; end
        else m_tec--;
      end
    end
    if (evt && en) m_irq = 1;
    else if (clr) m_irq = 0;
    @(negedge clk);
    if (m_done) done_pulses++;
    compare_all();
  endtask

  task automatic recessive_groups(int n, bit gap);
    for (int g = 0; g < n; g++)
      for (int b = 0; b < 11; b++) begin
        cyc(1, 1);
        if (gap) cyc(0, 0); // non-strobe dominant level must be ignored
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "tx after reset", int'(tx_err_cnt), 0);
    check("R9", "rx after reset", int'(rx_err_cnt), 0);
    check("R9", "bus_off after reset", int'(bus_off), 0);
    check("R9", "irq after reset", int'(warn_irq), 0);
    check("R9", "done after reset", int'(recovery_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: strobes while not bus-off change nothing
    for (int i = 0; i < 30; i++) cyc(1, 1);
    check("R3", "idle tx unchanged", int'(tx_err_cnt), 0);

    // R6: bus-off with interrupt disabled
    cyc(0, 1, 1, 0, 0);
    check("R6", "irq stays low when disabled", int'(warn_irq), 0);
    check("R2", "tx preset", int'(tx_err_cnt), 127);
    check("R1", "rx cleared", int'(rx_err_cnt), 0);

    // R3: one group with gaps between strobes
    recessive_groups(1, 1);
    check("R3", "one group", int'(tx_err_cnt), 126);

    // R4: ten recessive then a dominant, then ten more: no decrement
    for (int i = 0; i < 10; i++) cyc(1, 1);
    cyc(1, 0);
    for (int i = 0; i < 10; i++) cyc(1, 1);
    check("R4", "broken run no step", int'(tx_err_cnt), 126);
    cyc(1, 1);
    check("R4", "run completes after restart", int'(tx_err_cnt), 125);

    // R4: 22 recessive gives exactly two groups
    for (int i = 0; i < 22; i++) cyc(1, 1);
    check("R4", "no overlap", int'(tx_err_cnt), 123);

    // R8: restart mid-run with interrupt enabled; set beats clear (R7)
    for (int i = 0; i < 7; i++) cyc(1, 1);
    cyc(1, 1, 1, 1, 1);
    check("R8", "reload on restart", int'(tx_err_cnt), 127);
    check("R7", "set wins over clear", int'(warn_irq), 1);
    for (int i = 0; i < 10; i++) cyc(1, 1);
    check("R8", "partial run discarded", int'(tx_err_cnt), 127);
    cyc(1, 1);
    check("R8", "first group after restart", int'(tx_err_cnt), 126);

    // R7: irq held without clear, cleared by clear
    check("R7", "irq held", int'(warn_irq), 1);
    cyc(0, 1, 0, 0, 1);
    check("R7", "irq cleared", int'(warn_irq), 0);

    // R5: walk down to zero then the final group
    recessive_groups(126, 0);
    check("R5", "counter at zero", int'(tx_err_cnt), 0);
    check("R5", "still bus-off at zero", int'(bus_off), 1);
    for (int i = 0; i < 10; i++) cyc(1, 1);
    check("R5", "no early finish", int'(bus_off), 1);
    cyc(1, 1);
    check("R5", "done pulse", int'(recovery_done), 1);
    check("R5", "bus_off released", int'(bus_off), 0);
    cyc(1, 1);
    check("R5", "pulse single cycle", int'(recovery_done), 0);
    check("R5", "tx stays zero", int'(tx_err_cnt), 0);

    // Second full recovery with gaps, interrupt enabled
    cyc(0, 1, 1, 1, 0);
    check("R6", "irq raised when enabled", int'(warn_irq), 1);
    recessive_groups(128, 1);
    check("R5", "second recovery done", done_pulses, 2);
    check("R2", "released after second", int'(bus_off), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule